// File: doc/BRIEF.md
# USB Bus Event Interrupt Register

This block gathers the bus-level and protocol-level events of a USB device into one 8-bit interrupt request register. Two of the events come from the line itself. A single-ended zero (both data lines low) held past a debounce interval marks the start of a host bus reset. A sustained idle (J) state marks suspend. Both are measured by cycle-counting timers after a short synchronizer. The other four events arrive as one-cycle strobes from the protocol engine: setup token received, start of frame received, setup data stored and high-speed granted.

Each request bit is sticky. A bit stays set until software writes a 1 to its position. Reads never disturb it. A per-bit enable register gates the bits into a single interrupt output. Software clears requests by writing only the mask of the bits it has serviced. Writing back a value it has just read clears every request that was pending.

Top module: `usb_event_irq`

## Requirements
- R1: Bit positions in the request register (address 0) are: setup data stored = bit 0, start of frame = bit 1, setup token = bit 2, suspend = bit 3, bus reset = bit 4, high-speed granted = bit 5. A high strobe on setupDataStb, sofStb, setupTokenStb or hsGrantStb sets its bit at the next rising clock edge.
- R2: With the line at single-ended zero (dPlus=0, dMinus=0) continuously, bit 4 sets on the SYNC_STAGES+SE0_CYCLES-th rising edge after the line is first driven to that state, and not before. A shorter single-ended zero sets nothing.
- R3: With the line idle (dPlus=1, dMinus=0) continuously, bit 3 sets on the SYNC_STAGES+IDLE_CYCLES-th rising edge after the line goes idle. Any non-idle state, single-ended zero included, restarts the count.
- R4: A write to address 0 clears each bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R5: Reading either address changes no request bit.
- R6: Writing back the value just read from address 0 clears all requests that were pending.
- R7: When an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R8: Address 1 holds a per-bit enable with the same bit layout. irqOut is high exactly when some request bit and its enable bit are both 1.
- R9: Bits 7 and 6 of both addresses read as zero and ignore written values.
- R10: After reset, the request register, the enable register and irqOut are all zero.
- R11: Bus reset and suspend each set their bit once per episode. If the bit is cleared while the same line state continues, it does not set again until the line has left that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dPlus | input | 1 | D+ line level (asynchronous) |
| dMinus | input | 1 | D- line level (asynchronous) |
| setupDataStb | input | 1 | Pulse: all eight setup bytes stored |
| sofStb | input | 1 | Pulse: start-of-frame packet received |
| setupTokenStb | input | 1 | Pulse: setup token received |
| hsGrantStb | input | 1 | Pulse: high-speed operation granted |
| regAddr | input | 1 | Register select: 0 = requests, 1 = enables |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| irqOut | output | 1 | OR of enabled pending requests |

## Verification
The hardest cases to reach are the line-timer edges. A bit must stay clear one cycle short of the threshold and must be set exactly on it. A line state that breaks off at any point inside the window must restart the count. The bench uses small timer limits so that it can sweep every break-off length for both the single-ended-zero and idle timers, then re-arm each timer through a non-idle state. It also sweeps every combination of protocol events against every clear mask and every enable pattern.

// File: rtl/usb_event_irq_pkg.sv
package usb_event_irq_pkg;
  localparam int REG_W          = 8;
  localparam int EVT_COUNT      = 6;
  localparam int IDX_SETUP_DATA = 0;
  localparam int IDX_SOF        = 1;
  localparam int IDX_SETUP_TOK  = 2;
  localparam int IDX_SUSPEND    = 3;
  localparam int IDX_BUS_RESET  = 4;
  localparam int IDX_HS_GRANT   = 5;

  // Strobes from the line-state control to the register datapath.
  typedef struct packed {
    logic busResetHit;
    logic idleHit;
  } lineEvt_t;
endpackage

// File: rtl/usb_state_timer.sv
// Counts consecutive cycles of a condition; pulses once when the count reaches LIMIT.
module usb_state_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic active,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN)                count <= '0;
    else if (!active)         count <= '0;
    else if (count != TOP)    count <= count + 1'b1;  // saturate: one hit per episode
  end

  assign hit = active && (count == LAST);
endmodule

// File: rtl/usb_line_monitor.sv
// Control: synchronizes the line and times single-ended-zero and idle episodes.
module usb_line_monitor
  import usb_event_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SE0_CYCLES  = 150,
  parameter int IDLE_CYCLES = 180000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     dPlus,
  input  logic     dMinus,
  output lineEvt_t lineEvt
);
  localparam logic [1:0] LINE_K = 2'b01;  // {dPlus,dMinus}

  logic [1:0] syncQ [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[g] <= LINE_K;
        else       syncQ[g] <= {dPlus, dMinus};
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[g] <= LINE_K;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  logic [1:0] lineNow;
  logic       isSe0;
  logic       isIdle;

  assign lineNow = syncQ[SYNC_STAGES-1];
  assign isSe0   = (lineNow == 2'b00);
  assign isIdle  = (lineNow == 2'b10);

  usb_state_timer #(.LIMIT(SE0_CYCLES)) uSe0Timer (
    .clk(clk), .rstN(rstN), .active(isSe0), .hit(lineEvt.busResetHit)
  );

  usb_state_timer #(.LIMIT(IDLE_CYCLES)) uIdleTimer (
    .clk(clk), .rstN(rstN), .active(isIdle), .hit(lineEvt.idleHit)
  );
endmodule

// File: rtl/usb_irq_datapath.sv
// Datapath: sticky request bits, enable register, read mux, combined interrupt.
module usb_irq_datapath
  import usb_event_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  lineEvt_t             lineEvt,
  input  logic                 setupDataStb,
  input  logic                 sofStb,
  input  logic                 setupTokenStb,
  input  logic                 hsGrantStb,
  input  logic                 regAddr,
  input  logic                 regWrEn,
  input  logic [EVT_COUNT-1:0] wrBits,
  output logic [EVT_COUNT-1:0] statusBits,
  output logic [EVT_COUNT-1:0] enableBits,
  output logic [REG_W-1:0]     regRdData,
  output logic                 irqOut
);
  localparam int PAD_W = REG_W - EVT_COUNT;

  logic [EVT_COUNT-1:0] setVec;
  logic [EVT_COUNT-1:0] clrMask;

  always_comb begin
    setVec                = '0;
    setVec[IDX_SETUP_DATA] = setupDataStb;
    setVec[IDX_SOF]        = sofStb;
    setVec[IDX_SETUP_TOK]  = setupTokenStb;
    setVec[IDX_SUSPEND]    = lineEvt.idleHit;
    setVec[IDX_BUS_RESET]  = lineEvt.busResetHit;
    setVec[IDX_HS_GRANT]   = hsGrantStb;
  end

  assign clrMask = (regWrEn && !regAddr) ? wrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusBits <= '0;
      enableBits <= '0;
    end else begin
      statusBits <= (statusBits & ~clrMask) | setVec;  // set beats clear
      if (regWrEn && regAddr) enableBits <= wrBits;
    end
  end

  assign regRdData = regAddr ? {{PAD_W{1'b0}}, enableBits}
                             : {{PAD_W{1'b0}}, statusBits};
  assign irqOut    = |(statusBits & enableBits);
endmodule

// File: rtl/usb_event_irq.sv
module usb_event_irq
  import usb_event_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SE0_CYCLES  = 150,
  parameter int IDLE_CYCLES = 180000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dPlus,
  input  logic             dMinus,
  input  logic             setupDataStb,
  input  logic             sofStb,
  input  logic             setupTokenStb,
  input  logic             hsGrantStb,
  input  logic             regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irqOut
);
  lineEvt_t             lineEvt;
  logic [EVT_COUNT-1:0] statusBits;
  logic [EVT_COUNT-1:0] enableBits;
  logic                 unusedWrHi;

  assign unusedWrHi = ^regWrData[REG_W-1:EVT_COUNT];

  usb_line_monitor #(
    .SYNC_STAGES(SYNC_STAGES), .SE0_CYCLES(SE0_CYCLES), .IDLE_CYCLES(IDLE_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .dPlus(dPlus), .dMinus(dMinus), .lineEvt(lineEvt)
  );

  usb_irq_datapath uDp (
    .clk(clk), .rstN(rstN), .lineEvt(lineEvt),
    .setupDataStb(setupDataStb), .sofStb(sofStb),
    .setupTokenStb(setupTokenStb), .hsGrantStb(hsGrantStb),
    .regAddr(regAddr), .regWrEn(regWrEn), .wrBits(regWrData[EVT_COUNT-1:0]),
    .statusBits(statusBits), .enableBits(enableBits),
    .regRdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/usb_event_irq_checker.sv
module usb_event_irq_checker
  import usb_event_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 setupDataStb,
  input logic                 sofStb,
  input logic                 setupTokenStb,
  input logic                 hsGrantStb,
  input logic                 regAddr,
  input logic                 regWrEn,
  input logic [REG_W-1:0]     regWrData,
  input logic [EVT_COUNT-1:0] statusBits,
  input logic [EVT_COUNT-1:0] enableBits,
  input logic [REG_W-1:0]     regRdData,
  input logic                 irqOut
);
  assert_sof_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    sofStb |=> statusBits[IDX_SOF]);

  assert_hs_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    hsGrantStb |=> statusBits[IDX_HS_GRANT]);

  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr && regWrData[IDX_SETUP_TOK] && !setupTokenStb)
      |=> !statusBits[IDX_SETUP_TOK]);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && !regAddr)
      |=> ((statusBits & $past(statusBits)) == $past(statusBits)));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (setupDataStb && regWrEn && !regAddr && regWrData[IDX_SETUP_DATA])
      |=> statusBits[IDX_SETUP_DATA]);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enableBits == '0) |-> !irqOut);

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[REG_W-1:EVT_COUNT] == '0);
endmodule

bind usb_event_irq usb_event_irq_checker uChk (
  .clk(clk), .rstN(rstN), .setupDataStb(setupDataStb), .sofStb(sofStb),
  .setupTokenStb(setupTokenStb), .hsGrantStb(hsGrantStb),
  .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
  .statusBits(statusBits), .enableBits(enableBits),
  .regRdData(regRdData), .irqOut(irqOut)
);

// File: tb/usb_event_irq_test.sv
module usb_event_irq_test;
  localparam int SYNC = 2;
  localparam int SE0N = 4;
  localparam int IDLN = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dPlus = 1'b0, dMinus = 1'b1;
  logic       setupDataStb = 0, sofStb = 0, setupTokenStb = 0, hsGrantStb = 0;
  logic       regAddr = 0, regWrEn = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;

  usb_event_irq #(.SYNC_STAGES(SYNC), .SE0_CYCLES(SE0N), .IDLE_CYCLES(IDLN)) uut (
    .clk(clk), .rstN(rstN), .dPlus(dPlus), .dMinus(dMinus),
    .setupDataStb(setupDataStb), .sofStb(sofStb),
    .setupTokenStb(setupTokenStb), .hsGrantStb(hsGrantStb),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic rdReg(input logic a, output logic [7:0] v);
    regAddr = a; #1; v = regRdData; regAddr = 1'b0;
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; regAddr = 1'b0; regWrData = 8'h00;
  endtask

  task automatic pulse(input logic [5:0] m);
    setupDataStb = m[0]; sofStb = m[1]; setupTokenStb = m[2]; hsGrantStb = m[5];
    tick();
    setupDataStb = 0; sofStb = 0; setupTokenStb = 0; hsGrantStb = 0;
  endtask

  task automatic lineK();   dPlus = 0; dMinus = 1; endtask
  task automatic lineJ();   dPlus = 1; dMinus = 0; endtask
  task automatic lineSe0(); dPlus = 0; dMinus = 0; endtask

  function automatic logic [5:0] patOf(input int p);
    return {p[3], 2'b00, p[2:0]};
  endfunction

  initial begin
    logic [7:0] v, v2;
    @(negedge clk);
    tick(3);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    rdReg(0, v); chk("R10 status", v, 0);
    rdReg(1, v); chk("R10 enable", v, 0);
    chk("R10 irq", irqOut, 0);

    // R1 / R4 / R9: event patterns against every clear mask
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 64; m++) begin
        pulse(patOf(p));
        rdReg(0, v); chk("R1 set", v, patOf(p));
        wrReg(0, {2'b11, 6'(m)});
        rdReg(0, v); chk("R4 clear", v, patOf(p) & ~6'(m));
        wrReg(0, 8'h3F);
      end
    end

    // R5: reads leave requests untouched
    pulse(6'h27);
    for (int i = 0; i < 4; i++) begin
      rdReg(0, v); rdReg(1, v2); tick();
      rdReg(0, v); chk("R5 read no clear", v, 8'h27);
    end

    // R6: read-then-write-back clears everything pending
    rdReg(0, v);
    wrReg(0, v);
    rdReg(0, v); chk("R6 writeback clears all", v, 0);

    // R7: set wins over a same-cycle clear
    pulse(6'h03);
    sofStb = 1'b1;
    wrReg(0, 8'h03);
    sofStb = 1'b0;
    rdReg(0, v); chk("R7 set wins", v, 8'h02);
    wrReg(0, 8'h3F);

    // R8 / R9: every enable pattern against every event pattern
    for (int e = 0; e < 64; e++) begin
      wrReg(1, {2'b11, 6'(e)});
      rdReg(1, v); chk("R9 enable readback", v, e);
      for (int p = 0; p < 16; p++) begin
        pulse(patOf(p));
        chk("R8 irq", irqOut, ((patOf(p) & 6'(e)) != 0) ? 1 : 0);
        wrReg(0, 8'h3F);
        chk("R8 irq after clear", irqOut, 0);
      end
    end
    wrReg(1, 8'h00);

    // R2: bus reset threshold and short single-ended zeros
    for (int k = 1; k < SE0N; k++) begin
      lineSe0(); tick(k); lineK(); tick(SYNC + SE0N + 1);
      rdReg(0, v); chk("R2 short se0 ignored", v, 0);
    end
    lineSe0(); tick(SYNC + SE0N - 1);
    rdReg(0, v); chk("R2 before threshold", v[4], 0);
    tick();
    rdReg(0, v); chk("R2 at threshold", v[4], 1);
    wrReg(1, 8'h10);
    chk("R8 irq from bus reset", irqOut, 1);
    wrReg(0, 8'h10);
    tick(3 * SE0N);
    rdReg(0, v); chk("R11 reset once per episode", v[4], 0);
    lineK(); tick(SYNC + 1);
    lineSe0(); tick(SYNC + SE0N);
    rdReg(0, v); chk("R11 reset re-arms", v[4], 1);
    lineK(); tick(SYNC + 1);
    wrReg(0, 8'h3F); wrReg(1, 8'h00);

    // R3: suspend threshold, restart by K or single-ended zero
    for (int k = 1; k < IDLN; k++) begin
      lineJ(); tick(k);
      if (k % 2 == 0) lineK(); else lineSe0();
      tick();
      lineJ(); tick(SYNC + IDLN - 1);
      rdReg(0, v); chk("R3 restart before threshold", v[3], 0);
      tick();
      rdReg(0, v); chk("R3 at threshold", v, 8'h08);
      wrReg(0, 8'h08);
      tick(IDLN + 2);
      rdReg(0, v); chk("R11 suspend once per episode", v[3], 0);
      lineK(); tick(SYNC + 1);
    end

    finishRun();
  end
endmodule